// File: doc/BRIEF.md
# Timed-Access Unlock for Protected Control Bits

This block keeps a few critical control bits, such as a watchdog enable, safe from stray writes made by code that has lost control. It sits on a simple synchronous register bus with one write strobe per bus cycle. A protected bit changes only after a two-step key sequence has been written to a dedicated key register. The first key is 0xAA and the second key is 0x55, and the second key must follow the first within a bounded number of cycles. After the second key, a short window opens. Writes that land inside this window may change the protected bits. Writes that land outside it leave the protected bits as they are.

The control register holds both protected and unprotected bits. Unprotected bits are always writable. Writes to any other address are never blocked by this block. A read of the key register returns the window status in bit 0, and a read of the control register returns its current contents. The watchdog counter, reset generation and the processor are outside this block.

The default parameters place the key register at 0xC7 and the control register at 0xD8. Bit 1 of the control register is the protected watchdog enable, and the window is 3 cycles wide.

Top module: `ta_guard`

## Requirements
- R1: Synchronous active-high reset leaves the window closed and the sequence idle. After reset, `ctrl_q` reads 0x02, with bit 1 set (watchdog enabled).
- R2: A write of 0xAA to address 0xC7 arms the sequence. A write of 0x55 to 0xC7 arriving 1 to 3 cycles after that arming write opens the window, so 0, 1 or 2 idle cycles between the keys are accepted. `win_open` is high from the cycle after the 0x55 write.
- R3: A 0x55 write arriving 4 or more cycles after the 0xAA write opens nothing. The window, once open, closes by itself 3 cycles after the 0x55 write.
- R4: While armed, any write to 0xC7 of a value other than 0x55 or 0xAA returns the sequence to idle. A fresh 0xAA write re-arms the sequence and restarts its count.
- R5: The protected bits of the control register (mask 0x02 at address 0xD8) take the written value only if the write lands 1 to 3 cycles after the 0x55 write. A later write leaves those bits unchanged.
- R6: Every protected write inside the window is accepted. A protected write after the window is rejected even if an earlier write in the same window was accepted.
- R7: A whole-register write to 0xD8 always updates the unprotected bits. It updates the protected bits only as R5 allows, so a whole-register write is gated exactly like a single-bit change.
- R8: Writes to addresses other than 0xC7 and 0xD8 leave `ctrl_q` unchanged. They also neither abort nor restart the key sequence.
- R9: `rd_data` gives the following values: at `rd_addr` 0xC7, a status byte with bit 0 equal to the window state and all other bits zero; at 0xD8, the control register; at any other address, zero.
- R10: A write to 0xC7 while the window is open closes it. If the value written is 0xAA, that write re-arms the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one bus write per cycle |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data (key-register status or control register) |
| ctrl_q | output | 8 | Control register contents, including protected bits |
| win_open | output | 1 | High while a protected write would be accepted |

## Verification
Two events can coincide in the last cycle of the window. In that cycle a protected write lands at the same clock edge where the window expires. That write must still be accepted, and a write one cycle later must be rejected. Directed cases place protected writes and second keys exactly at 3 and at 4 cycles after the preceding key. Random traffic biased toward the two addresses and the two key values produces many more such coincidences. Every cycle is judged against a bench model that tracks the age of the last key write rather than any counter.

// File: rtl/ta_guard_pkg.sv
package ta_guard_pkg;
   typedef enum logic [1:0] {
      TA_IDLE  = 2'd0,
      TA_ARMED = 2'd1,
      TA_OPEN  = 2'd2
   } ta_phase_e;
endpackage

// File: rtl/ta_key_seq.sv
module ta_key_seq
   import ta_guard_pkg::*;
#(
   parameter int AW = 8,
   parameter int DW = 8,
   parameter logic [AW-1:0] KEY_ADDR = 8'hC7,
   parameter logic [DW-1:0] KEY1 = 8'hAA,
   parameter logic [DW-1:0] KEY2 = 8'h55,
   parameter int WIN_CYC = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   output logic          win_open_o
);
   localparam int CNT_W = $clog2(WIN_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WIN_CYC);
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   if (WIN_CYC < 1) begin : g_bad_win
      $error("WIN_CYC must be at least 1");
   end
   if (KEY1 == KEY2) begin : g_bad_keys
      $error("KEY1 and KEY2 must differ");
   end

   ta_phase_e        phase_q, phase_n;
   logic [CNT_W-1:0] cnt_q, cnt_n;
   logic             key_hit;

   assign key_hit = wr_en && (wr_addr == KEY_ADDR);

   always_comb begin
      phase_n = phase_q;
      cnt_n   = cnt_q;
      if (phase_q != TA_IDLE) begin
         if (cnt_q == CNT_ONE) begin
            phase_n = TA_IDLE;
            cnt_n   = '0;
         end else begin
            cnt_n = cnt_q - CNT_ONE;
         end
      end
      if (key_hit) begin
         if (wr_data == KEY1) begin
            phase_n = TA_ARMED;
            cnt_n   = CNT_LOAD;
         end else if (wr_data == KEY2 && phase_q == TA_ARMED) begin
            phase_n = TA_OPEN;
            cnt_n   = CNT_LOAD;
         end else begin
            phase_n = TA_IDLE;
            cnt_n   = '0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= TA_IDLE;
         cnt_q   <= '0;
      end else begin
         phase_q <= phase_n;
         cnt_q   <= cnt_n;
      end
   end

   assign win_open_o = (phase_q == TA_OPEN);

   // Independent age counter used only by the window checks.
   logic [CNT_W:0] chk_age;
   always_ff @(posedge clk) begin
      if (rst) begin
         chk_age <= '0;
      end else if (key_hit && (wr_data == KEY1 || (wr_data == KEY2 && phase_q == TA_ARMED))) begin
         chk_age <= '0;
      end else if (chk_age <= (CNT_W+1)'(WIN_CYC)) begin
         chk_age <= chk_age + 1'b1;
      end
   end

   // R2
   key2_opens_chk: assert property (@(posedge clk) disable iff (rst)
      (key_hit && wr_data == KEY2 && phase_q == TA_ARMED) |=> win_open_o);
   // R3
   window_bound_chk: assert property (@(posedge clk) disable iff (rst)
      (phase_q != TA_IDLE) |-> (chk_age < (CNT_W+1)'(WIN_CYC)));
   // R4
   bad_key_aborts_chk: assert property (@(posedge clk) disable iff (rst)
      (key_hit && wr_data != KEY1 && wr_data != KEY2) |=> (phase_q == TA_IDLE));
   // R10
   rearm_closes_chk: assert property (@(posedge clk) disable iff (rst)
      (key_hit && wr_data == KEY1) |=> (!win_open_o && phase_q == TA_ARMED));
endmodule

// File: rtl/ta_prot_reg.sv
module ta_prot_reg #(
   parameter int AW = 8,
   parameter int DW = 8,
   parameter logic [AW-1:0] CTRL_ADDR = 8'hD8,
   parameter logic [DW-1:0] PROT_MASK = 8'h02,
   parameter logic [DW-1:0] CTRL_RST  = 8'h02
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          unlock_i,
   output logic [DW-1:0] q_o
);
   if (PROT_MASK == '0) begin : g_bad_mask
      $error("PROT_MASK must select at least one bit");
   end

   logic hit;
   assign hit = wr_en && (wr_addr == CTRL_ADDR);

   for (genvar i = 0; i < DW; i++) begin : g_bit
      if (PROT_MASK[i]) begin : g_guarded
         always_ff @(posedge clk) begin
            if (rst)                q_o[i] <= CTRL_RST[i];
            else if (hit && unlock_i) q_o[i] <= wr_data[i];
         end
      end else begin : g_free
         always_ff @(posedge clk) begin
            if (rst)      q_o[i] <= CTRL_RST[i];
            else if (hit) q_o[i] <= wr_data[i];
         end
      end
   end

   // R5
   locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(hit && unlock_i) |=> $stable(q_o & PROT_MASK));
   // R7
   free_bits_chk: assert property (@(posedge clk) disable iff (rst)
      hit |=> ((q_o & ~PROT_MASK) == ($past(wr_data) & ~PROT_MASK)));
   // R8
   other_addr_chk: assert property (@(posedge clk) disable iff (rst)
      !hit |=> $stable(q_o));
endmodule

// File: rtl/ta_guard.sv
module ta_guard #(
   parameter int AW = 8,
   parameter int DW = 8,
   parameter logic [AW-1:0] KEY_ADDR  = 8'hC7,
   parameter logic [AW-1:0] CTRL_ADDR = 8'hD8,
   parameter logic [DW-1:0] KEY1      = 8'hAA,
   parameter logic [DW-1:0] KEY2      = 8'h55,
   parameter int WIN_CYC              = 3,
   parameter logic [DW-1:0] PROT_MASK = 8'h02,
   parameter logic [DW-1:0] CTRL_RST  = 8'h02
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   output logic [DW-1:0] ctrl_q,
   output logic          win_open
);
   if (KEY_ADDR == CTRL_ADDR) begin : g_bad_map
      $error("KEY_ADDR and CTRL_ADDR must differ");
   end

   ta_key_seq #(
      .AW(AW), .DW(DW), .KEY_ADDR(KEY_ADDR),
      .KEY1(KEY1), .KEY2(KEY2), .WIN_CYC(WIN_CYC)
   ) seq_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .win_open_o(win_open)
   );

   ta_prot_reg #(
      .AW(AW), .DW(DW), .CTRL_ADDR(CTRL_ADDR),
      .PROT_MASK(PROT_MASK), .CTRL_RST(CTRL_RST)
   ) reg_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .unlock_i(win_open), .q_o(ctrl_q)
   );

   always_comb begin
      if (rd_addr == KEY_ADDR)       rd_data = {{(DW-1){1'b0}}, win_open};
      else if (rd_addr == CTRL_ADDR) rd_data = ctrl_q;
      else                           rd_data = '0;
   end
endmodule

// File: tb/ta_guard_tb.sv
module ta_guard_tb_top;
   logic       clk = 1'b0;
   logic       rst;
   logic       wr_en;
   logic [7:0] wr_addr, wr_data, rd_addr;
   logic [7:0] rd_data, ctrl_q;
   logic       win_open;

   int errors = 0;
   int checks = 0;

   // bench model, based on the age of the last accepted key write
   int   cyc = 0;
   int   m_phase = 0;        // 0 idle, 1 armed, 2 open
   int   m_kc = -100;        // cycle of the last accepted key write
   logic [7:0] m_ctrl = 8'h02;

   always #4 clk = ~clk;

   ta_guard dut_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .ctrl_q(ctrl_q), .win_open(win_open)
   );

   function automatic int eff_phase(int c);
      return (m_phase != 0 && (c - m_kc) <= 3) ? m_phase : 0;
   endfunction

   function automatic logic exp_win(int c);
      return (m_phase == 2) && ((c + 1 - m_kc) <= 3);
   endfunction

   function automatic logic [7:0] exp_rd(logic [7:0] a, int c);
      if (a == 8'hC7) return {7'b0, exp_win(c)};
      if (a == 8'hD8) return m_ctrl;
      return 8'h00;
   endfunction

   task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
      end
   endtask

   task automatic model_update(logic we, logic [7:0] a, logic [7:0] d);
      int e;
      e = eff_phase(cyc);
      if (!we) return;
      if (a == 8'hC7) begin
         if (d == 8'hAA) begin m_phase = 1; m_kc = cyc; end
         else if (d == 8'h55 && e == 1) begin m_phase = 2; m_kc = cyc; end
         else m_phase = 0;
      end else if (a == 8'hD8) begin
         if (e == 2) m_ctrl = d;
         else m_ctrl = (d & ~8'h02) | (m_ctrl & 8'h02);
      end
   endtask

   task automatic step(string tag, logic we, logic [7:0] a, logic [7:0] d, logic [7:0] ra);
      @(negedge clk);
      wr_en = we; wr_addr = a; wr_data = d; rd_addr = ra;
      @(posedge clk);
      cyc++;
      model_update(we, a, d);
      #1;
      check(tag, "ctrl_q", ctrl_q, m_ctrl);
      check(tag, "win_open", {7'b0, win_open}, {7'b0, exp_win(cyc)});
      check(tag, "rd_data", rd_data, exp_rd(ra, cyc));
   endtask

   task automatic idle(string tag, int n);
      for (int i = 0; i < n; i++) step(tag, 1'b0, 8'h00, 8'h00, 8'hC7);
   endtask

   task automatic wr(string tag, logic [7:0] a, logic [7:0] d);
      step(tag, 1'b1, a, d, 8'hC7);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] ra, a, d;
      int r;
      void'($urandom(32'd4242));
      rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = 8'hD8;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      // R1 reset state
      check("R1", "ctrl_q", ctrl_q, 8'h02);
      check("R1", "win_open", {7'b0, win_open}, 8'h00);
      check("R1", "rd_data", rd_data, 8'h02);

      // R2 back-to-back keys, R5 write at d=1, R6 second write at d=2, rejected late one
      wr("R2", 8'hC7, 8'hAA); wr("R2", 8'hC7, 8'h55);
      wr("R5", 8'hD8, 8'h00); wr("R6", 8'hD8, 8'h02);
      idle("R6", 2); wr("R6", 8'hD8, 8'h00);
      // R2 one- and two-cycle gaps; R3 three-cycle gap fails
      wr("R2", 8'hC7, 8'hAA); idle("R2", 1); wr("R2", 8'hC7, 8'h55); idle("R3", 3);
      wr("R2", 8'hC7, 8'hAA); idle("R2", 2); wr("R2", 8'hC7, 8'h55); idle("R3", 3);
      wr("R3", 8'hC7, 8'hAA); idle("R3", 3); wr("R3", 8'hC7, 8'h55); idle("R3", 1);
      // R5 protected write in the last window cycle, then one cycle too late
      wr("R5", 8'hC7, 8'hAA); wr("R5", 8'hC7, 8'h55); idle("R5", 2); wr("R5", 8'hD8, 8'h00);
      wr("R5", 8'hC7, 8'hAA); wr("R5", 8'hC7, 8'h55); idle("R5", 3); wr("R5", 8'hD8, 8'h02);
      // R4 wrong key aborts, re-arm restarts
      wr("R4", 8'hC7, 8'hAA); wr("R4", 8'hC7, 8'h12); wr("R4", 8'hC7, 8'h55);
      wr("R4", 8'hC7, 8'hAA); idle("R4", 2); wr("R4", 8'hC7, 8'hAA); idle("R4", 2);
      wr("R4", 8'hC7, 8'h55); idle("R4", 3);
      // R7 whole-register writes while locked
      wr("R7", 8'hD8, 8'hFD); wr("R7", 8'hD8, 8'hF0);
      // R8 other addresses neither touch ctrl nor abort
      wr("R8", 8'hC7, 8'hAA); wr("R8", 8'h10, 8'h55); wr("R8", 8'hC7, 8'h55);
      wr("R8", 8'h20, 8'hFF); wr("R8", 8'hD8, 8'h02); idle("R8", 3);
      // R10 re-arm while open closes the window
      wr("R10", 8'hC7, 8'hAA); wr("R10", 8'hC7, 8'h55); wr("R10", 8'hC7, 8'hAA);
      wr("R10", 8'hD8, 8'h00); wr("R10", 8'hC7, 8'h55); wr("R10", 8'hD8, 8'h00);
      wr("R10", 8'hC7, 8'h33); wr("R10", 8'hD8, 8'h02);
      // R9 reads of each address
      step("R9", 1'b0, 8'h00, 8'h00, 8'hD8);
      step("R9", 1'b0, 8'h00, 8'h00, 8'h44);

      // random traffic
      for (int n = 0; n < 4000; n++) begin
         r = $urandom_range(0, 9);
         a = (r < 4) ? 8'hC7 : (r < 7) ? 8'hD8 : 8'($urandom);
         r = $urandom_range(0, 9);
         d = (r < 3) ? 8'hAA : (r < 6) ? 8'h55 : (r < 7) ? 8'h00 : (r < 8) ? 8'h02 : 8'($urandom);
         r = $urandom_range(0, 2);
         ra = (r == 0) ? 8'hC7 : (r == 1) ? 8'hD8 : 8'h3C;
         step("R5 R9 random", ($urandom_range(0, 9) < 6), a, d, ra);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule